// File: doc/BRIEF.md
# Operand Bypass Network Selector

This block chooses where each of the two ALU source operands of a five-stage pipeline comes from. Its inputs are the two source register indices of the instruction in decode and the register file data read for them. It also sees the destination index, valid bit, write enable and result of the instructions in execute, memory and writeback. For each operand it picks the register file value or a result forwarded from one of the three later stages. It reports the choice as a 2-bit select code and loads the chosen value into the operand latch at the clock edge.

The execute stage forwards its ALU output. For a jump-and-link it forwards the link value instead, which is the instruction address plus a fixed step. The memory stage forwards load data for a load and its ALU result for anything else. Writeback forwards its final value. Register zero is never forwarded. A load in execute cannot be forwarded because its data does not exist yet. When a decode source depends on such a load, the block raises a flag for the stall logic and the operand latches keep their contents.

Top module: `operand_bypass`

## Requirements
- R1: While rst_ni is low, both operand latches read zero, and this applies asynchronously.
- R2: When no later stage matches a source, the select code is 0 and the latch loads that source's register-file data at the next edge.
- R3: A valid, writing, non-load instruction in execute whose destination equals a source gives select code 1, and the latch loads the execute ALU result.
- R4: When that execute-stage producer is a jump-and-link, the forwarded value is its instruction address plus LINK_INC (4) and not the ALU result.
- R5: A match in memory gives select code 2. The forwarded value is the load data if the memory-stage instruction is a load, and the memory ALU result otherwise.
- R6: A match in writeback gives select code 3, and the latch loads the writeback value.
- R7: When more than one stage matches, the youngest wins: execute over memory over writeback over the register file.
- R8: Source index 0 always gives select code 0, and a destination of 0 never matches.
- R9: A stage whose valid bit or write enable is low never matches.
- R10: A valid, writing load in execute whose non-zero destination equals either source raises no_fwd_o in the same cycle. While no_fwd_o is high, neither operand latch changes at the edge.
- R11: The two operands are selected independently: each gets its own code and value from its own source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| id_rs1_i | input | REG_AW | Decode source index, operand A |
| id_rs2_i | input | REG_AW | Decode source index, operand B |
| rf_rs1_data_i | input | XLEN | Register file data for operand A |
| rf_rs2_data_i | input | XLEN | Register file data for operand B |
| ex_valid_i | input | 1 | Execute stage holds an instruction |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_rd_i | input | REG_AW | Execute destination index |
| ex_is_load_i | input | 1 | Execute instruction is a load |
| ex_is_link_i | input | 1 | Execute instruction is a jump-and-link |
| ex_pc_i | input | XLEN | Execute instruction address |
| ex_alu_i | input | XLEN | Execute ALU output |
| mem_valid_i | input | 1 | Memory stage holds an instruction |
| mem_we_i | input | 1 | Memory instruction writes a register |
| mem_rd_i | input | REG_AW | Memory destination index |
| mem_is_load_i | input | 1 | Memory instruction is a load |
| mem_alu_i | input | XLEN | Memory-stage ALU result |
| mem_load_data_i | input | XLEN | Data returned by the load |
| wb_valid_i | input | 1 | Writeback stage holds an instruction |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| wb_rd_i | input | REG_AW | Writeback destination index |
| wb_data_i | input | XLEN | Writeback value |
| sel_a_o | output | 2 | Operand A source: 0 regfile, 1 execute, 2 memory, 3 writeback |
| sel_b_o | output | 2 | Operand B source, same coding |
| no_fwd_o | output | 1 | A source depends on a load still in execute |
| op_a_o | output | XLEN | Operand A latch |
| op_b_o | output | XLEN | Operand B latch |

## Verification
Each stage's result bus carries its own distinct constant. Every check of an operand value therefore shows which path was taken, and the ALU, link, load and ALU-in-memory variants of the execute and memory paths can be told apart. The patterns cover a single producer in each stage, all three stages matching at once, and only the two older stages matching, which expose the priority order. They also cover disabled stages, register zero, and a source on each operand matched by a different stage, which separates the two selects. A load-in-execute pattern, and a load whose destination matches no source, separate a real conflict from a false one.

// File: rtl/byp_pkg.sv
package byp_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/byp_src_pick.sv
module byp_src_pick
  import byp_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              ex_en_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              mem_en_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              wb_en_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  output src_sel_e          sel_o
);
  logic src_live;
  logic hit_ex, hit_mem, hit_wb;

  // index zero is hardwired, never a forwarding target
  assign src_live = (src_i != '0);
  assign hit_ex   = src_live && ex_en_i  && (ex_rd_i  == src_i);
  assign hit_mem  = src_live && mem_en_i && (mem_rd_i == src_i);
  assign hit_wb   = src_live && wb_en_i  && (wb_rd_i  == src_i);

  // youngest producer wins
  always_comb begin
    if (hit_ex)       sel_o = SRC_EX;
    else if (hit_mem) sel_o = SRC_MEM;
    else if (hit_wb)  sel_o = SRC_WB;
    else              sel_o = SRC_RF;
  end
endmodule

// File: rtl/byp_stage_val.sv
module byp_stage_val #(
  parameter int XLEN     = 32,
  parameter int LINK_INC = 4
) (
  input  logic [XLEN-1:0] ex_alu_i,
  input  logic [XLEN-1:0] ex_pc_i,
  input  logic            ex_is_link_i,
  input  logic [XLEN-1:0] mem_alu_i,
  input  logic [XLEN-1:0] mem_load_data_i,
  input  logic            mem_is_load_i,
  output logic [XLEN-1:0] ex_fwd_o,
  output logic [XLEN-1:0] mem_fwd_o
);
  localparam logic [XLEN-1:0] LinkStep = XLEN'(LINK_INC);

  logic [XLEN-1:0] link_val;
  assign link_val  = ex_pc_i + LinkStep;
  assign ex_fwd_o  = ex_is_link_i  ? link_val        : ex_alu_i;
  assign mem_fwd_o = mem_is_load_i ? mem_load_data_i : mem_alu_i;
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
  import byp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_AW   = 5,
  parameter int LINK_INC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [XLEN-1:0]   rf_rs1_data_i,
  input  logic [XLEN-1:0]   rf_rs2_data_i,
  input  logic              ex_valid_i,
  input  logic              ex_we_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_is_load_i,
  input  logic              ex_is_link_i,
  input  logic [XLEN-1:0]   ex_pc_i,
  input  logic [XLEN-1:0]   ex_alu_i,
  input  logic              mem_valid_i,
  input  logic              mem_we_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_is_load_i,
  input  logic [XLEN-1:0]   mem_alu_i,
  input  logic [XLEN-1:0]   mem_load_data_i,
  input  logic              wb_valid_i,
  input  logic              wb_we_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic [XLEN-1:0]   wb_data_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic              no_fwd_o,
  output logic [XLEN-1:0]   op_a_o,
  output logic [XLEN-1:0]   op_b_o
);
  localparam int NumOps = 2;

  logic              ex_en, mem_en, wb_en;
  logic [XLEN-1:0]   ex_fwd, mem_fwd;
  logic [REG_AW-1:0] src    [NumOps];
  logic [XLEN-1:0]   rf_val [NumOps];
  src_sel_e          sel    [NumOps];
  logic [XLEN-1:0]   op_nxt [NumOps];
  logic [XLEN-1:0]   op_q   [NumOps];
  logic [NumOps-1:0] ld_conf;

  assign ex_en  = ex_valid_i  && ex_we_i;
  assign mem_en = mem_valid_i && mem_we_i;
  assign wb_en  = wb_valid_i  && wb_we_i;

  assign src[0]    = id_rs1_i;
  assign src[1]    = id_rs2_i;
  assign rf_val[0] = rf_rs1_data_i;
  assign rf_val[1] = rf_rs2_data_i;

  byp_stage_val #(.XLEN(XLEN), .LINK_INC(LINK_INC)) u_val (
    .ex_alu_i        (ex_alu_i),
    .ex_pc_i         (ex_pc_i),
    .ex_is_link_i    (ex_is_link_i),
    .mem_alu_i       (mem_alu_i),
    .mem_load_data_i (mem_load_data_i),
    .mem_is_load_i   (mem_is_load_i),
    .ex_fwd_o        (ex_fwd),
    .mem_fwd_o       (mem_fwd)
  );

  for (genvar g = 0; g < NumOps; g++) begin : g_op
    byp_src_pick #(.REG_AW(REG_AW)) u_pick (
      .src_i    (src[g]),
      .ex_en_i  (ex_en),
      .ex_rd_i  (ex_rd_i),
      .mem_en_i (mem_en),
      .mem_rd_i (mem_rd_i),
      .wb_en_i  (wb_en),
      .wb_rd_i  (wb_rd_i),
      .sel_o    (sel[g])
    );

    always_comb begin
      unique case (sel[g])
        SRC_EX:  op_nxt[g] = ex_fwd;
        SRC_MEM: op_nxt[g] = mem_fwd;
        SRC_WB:  op_nxt[g] = wb_data_i;
        default: op_nxt[g] = rf_val[g];
      endcase
    end

    // load result not ready while still in execute
    assign ld_conf[g] = (sel[g] == SRC_EX) && ex_is_load_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        op_q[g] <= '0;
      else if (!no_fwd_o) op_q[g] <= op_nxt[g];
    end
  end

  assign no_fwd_o = |ld_conf;
  assign sel_a_o  = sel[0];
  assign sel_b_o  = sel[1];
  assign op_a_o   = op_q[0];
  assign op_b_o   = op_q[1];

  AST_ZERO_SRC_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs1_i == '0) |-> (sel_a_o == 2'd0)); // R8
  AST_ZERO_SRC_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs2_i == '0) |-> (sel_b_o == 2'd0)); // R8
  AST_FLAG_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_fwd_o |-> (ex_is_load_i && ex_valid_i && ex_we_i)); // R10
  AST_HOLD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_fwd_o |=> $stable(op_a_o)); // R10
  AST_HOLD_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_fwd_o |=> $stable(op_b_o)); // R10
  AST_EX_ALU_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!no_fwd_o && sel_a_o == 2'd1 && !ex_is_link_i) |=> (op_a_o == $past(ex_alu_i))); // R3
  AST_WB_MATCH_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_o == 2'd3) |-> (wb_rd_i == id_rs1_i && wb_valid_i && wb_we_i)); // R6
  AST_EX_PRIO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && ex_we_i && ex_rd_i == id_rs2_i && id_rs2_i != '0) |-> (sel_b_o == 2'd1)); // R7
endmodule

// File: tb/sim_operand_bypass.sv
module sim_operand_bypass;
  localparam int XLEN = 32;
  localparam int AW   = 5;

  localparam logic [31:0] RF1 = 32'h1111_1111, RF2 = 32'h2222_2222;
  localparam logic [31:0] EXA = 32'h3333_3333, EXPC = 32'h0000_1000;
  localparam logic [31:0] MA  = 32'h5555_5555, ML = 32'h6666_6666;
  localparam logic [31:0] WBD = 32'h7777_7777;

  typedef struct packed {
    logic [3:0]    req;
    logic [AW-1:0] rs1, rs2;
    logic exv, exwe; logic [AW-1:0] exrd; logic exld, exlk;
    logic mv, mwe;   logic [AW-1:0] mrd;  logic mld;
    logic wv, wwe;   logic [AW-1:0] wrd;
    logic [1:0] ea, eb; logic enf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R2 nothing in flight
    '{4'd2,  5'd1, 5'd2, 1'b0,1'b0,5'd0,1'b0,1'b0, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 2'd0,2'd0,1'b0},
    // R3 ALU in execute
    '{4'd3,  5'd1, 5'd2, 1'b1,1'b1,5'd1,1'b0,1'b0, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 2'd1,2'd0,1'b0},
    // R4 link in execute
    '{4'd4,  5'd1, 5'd2, 1'b1,1'b1,5'd2,1'b0,1'b1, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 2'd0,2'd1,1'b0},
    // R5 ALU in memory
    '{4'd5,  5'd1, 5'd2, 1'b0,1'b0,5'd0,1'b0,1'b0, 1'b1,1'b1,5'd1,1'b0, 1'b0,1'b0,5'd0, 2'd2,2'd0,1'b0},
    // R5 load in memory
    '{4'd5,  5'd1, 5'd2, 1'b0,1'b0,5'd0,1'b0,1'b0, 1'b1,1'b1,5'd2,1'b1, 1'b0,1'b0,5'd0, 2'd0,2'd2,1'b0},
    // R6 writeback
    '{4'd6,  5'd1, 5'd2, 1'b0,1'b0,5'd0,1'b0,1'b0, 1'b0,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd1, 2'd3,2'd0,1'b0},
    // R7 all three match
    '{4'd7,  5'd1, 5'd1, 1'b1,1'b1,5'd1,1'b0,1'b0, 1'b1,1'b1,5'd1,1'b0, 1'b1,1'b1,5'd1, 2'd1,2'd1,1'b0},
    // R7 memory over writeback
    '{4'd7,  5'd1, 5'd2, 1'b0,1'b0,5'd0,1'b0,1'b0, 1'b1,1'b1,5'd2,1'b0, 1'b1,1'b1,5'd2, 2'd0,2'd2,1'b0},
    // R8 register zero
    '{4'd8,  5'd0, 5'd0, 1'b1,1'b1,5'd0,1'b0,1'b0, 1'b1,1'b1,5'd0,1'b0, 1'b1,1'b1,5'd0, 2'd0,2'd0,1'b0},
    // R9 no write enable / invalid
    '{4'd9,  5'd1, 5'd2, 1'b1,1'b0,5'd1,1'b0,1'b0, 1'b0,1'b1,5'd1,1'b0, 1'b1,1'b1,5'd1, 2'd3,2'd0,1'b0},
    // R10 load in execute, latches hold
    '{4'd10, 5'd1, 5'd2, 1'b1,1'b1,5'd1,1'b1,1'b0, 1'b0,1'b0,5'd0,1'b0, 1'b0,1'b0,5'd0, 2'd1,2'd0,1'b1},
    // R11 independent selects
    '{4'd11, 5'd3, 5'd4, 1'b1,1'b1,5'd4,1'b0,1'b0, 1'b0,1'b0,5'd0,1'b0, 1'b1,1'b1,5'd3, 2'd3,2'd1,1'b0},
    // R10 load in execute, no match
    '{4'd10, 5'd5, 5'd6, 1'b1,1'b1,5'd7,1'b1,1'b0, 1'b1,1'b1,5'd6,1'b1, 1'b0,1'b0,5'd0, 2'd0,2'd2,1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] id_rs1_i = '0, id_rs2_i = '0, ex_rd_i = '0, mem_rd_i = '0, wb_rd_i = '0;
  logic ex_valid_i = 0, ex_we_i = 0, ex_is_load_i = 0, ex_is_link_i = 0;
  logic mem_valid_i = 0, mem_we_i = 0, mem_is_load_i = 0, wb_valid_i = 0, wb_we_i = 0;
  logic [1:0] sel_a_o, sel_b_o;
  logic no_fwd_o;
  logic [XLEN-1:0] op_a_o, op_b_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  operand_bypass u0 (
    .clk_i, .rst_ni, .id_rs1_i, .id_rs2_i,
    .rf_rs1_data_i(RF1), .rf_rs2_data_i(RF2),
    .ex_valid_i, .ex_we_i, .ex_rd_i, .ex_is_load_i, .ex_is_link_i,
    .ex_pc_i(EXPC), .ex_alu_i(EXA),
    .mem_valid_i, .mem_we_i, .mem_rd_i, .mem_is_load_i,
    .mem_alu_i(MA), .mem_load_data_i(ML),
    .wb_valid_i, .wb_we_i, .wb_rd_i, .wb_data_i(WBD),
    .sel_a_o, .sel_b_o, .no_fwd_o, .op_a_o, .op_b_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_val(logic [1:0] s, logic [31:0] rf, logic lk, logic mld);
    case (s)
      2'd1:    return lk ? EXPC + 32'd4 : EXA;
      2'd2:    return mld ? ML : MA;
      2'd3:    return WBD;
      default: return rf;
    endcase
  endfunction

  initial begin
    logic [31:0] pa, pb, na, nb;
    #1;
    chk("R1 reset op_a", op_a_o, '0);
    chk("R1 reset op_b", op_b_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    pa = '0; pb = '0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VEC[i];
      t = $sformatf("R%0d v%0d", v.req, i);
      @(negedge clk_i);
      id_rs1_i = v.rs1; id_rs2_i = v.rs2;
      ex_valid_i = v.exv; ex_we_i = v.exwe; ex_rd_i = v.exrd;
      ex_is_load_i = v.exld; ex_is_link_i = v.exlk;
      mem_valid_i = v.mv; mem_we_i = v.mwe; mem_rd_i = v.mrd; mem_is_load_i = v.mld;
      wb_valid_i = v.wv; wb_we_i = v.wwe; wb_rd_i = v.wrd;
      #1;
      chk({t, " sel_a"}, 32'(sel_a_o), 32'(v.ea));
      chk({t, " sel_b"}, 32'(sel_b_o), 32'(v.eb));
      chk({t, " no_fwd"}, 32'(no_fwd_o), 32'(v.enf));
      na = v.enf ? pa : exp_val(v.ea, RF1, v.exlk, v.mld);
      nb = v.enf ? pb : exp_val(v.eb, RF2, v.exlk, v.mld);
      @(posedge clk_i); #1;
      chk({t, " op_a"}, op_a_o, na);
      chk({t, " op_b"}, op_b_o, nb);
      pa = na; pb = nb;
    end
    // R1 asynchronous reset mid-run
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R1 async op_a", op_a_o, '0);
    chk("R1 async op_b", op_b_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule